// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and a word-wide memory port. It holds 64 lines of 16 bytes each. Each line has its own stored tag and presence flag. Loads that hit are answered combinationally in the same cycle. A load that misses holds the processor until all four words of the line have been read from memory. It then returns the requested word.

Every store is sent on to memory through a four-entry queue of address/data pairs, so the processor normally moves on at once. A store that hits also updates the cached word. A store that misses leaves the cache untouched, and no line is allocated for it. Before a load miss reads memory, it waits until the queue is empty. This way a refill never picks up a value older than a store that is still queued.

The processor drives `cpu_req` and keeps the request unchanged while `cpu_stall` is high. The request completes at the first rising edge where `cpu_stall` is low. On the memory side, `mem_req` and its address, data and direction stay steady until `mem_ready` completes the transfer. Read data on `mem_rdata` is taken in the cycle where `mem_ready` is high.

Top module: `wtc_cache_top`

## Requirements
- R1: The byte address splits from the top down into a 22-bit tag, a 6-bit line index (bits 9:4), a 2-bit word select (bits 3:2) and 2 ignored byte bits (1:0). Two addresses that differ only in bits 1:0 return the same word.
- R2: The line used is the block address modulo 64. Two addresses with the same index and different tags evict each other, so re-reading the first one misses again.
- R3: A load hits only when the indexed line's presence flag is set and its stored tag equals the address tag. A load hit returns the word in the same cycle with `cpu_stall` low.
- R4: After reset every presence flag is 0, `cpu_stall` is low with no request, and `mem_req` is low. The first load to any address misses.
- R5: A load miss raises `cpu_stall` and performs exactly four memory reads, word 0 to word 3 of the line. It then returns the requested word and releases the stall.
- R6: After a refill, loads to the other words of the same line hit without further memory reads.
- R7: A store hit updates the cached word, so a later load returns the new value. The store also reaches memory.
- R8: A store miss allocates no line. A following load to that address misses, and it returns the stored value fetched from memory.
- R9: A load miss starts its refill reads only after the store queue is empty, so the refill sees every earlier store.
- R10: Stores complete without a stall while the queue holds fewer than 4 entries. A store raises `cpu_stall` while the queue holds 4 entries.
- R11: The queue writes memory in arrival order, one write per `mem_ready`, so the last of two stores to one address is what memory keeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when a load is not stalled |
| cpu_stall | output | 1 | Hold the current request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Transfer completes this cycle |

## Verification
The embedded properties watch, on every cycle, the following: the queue never takes a push when full or a pop when empty; a refill never runs while queued stores remain; a load miss always leaves the idle state; an accepted store miss leaves the presence flags unchanged; reset clears the flags. Other behaviour can only be shown by the bench's scenarios. These are the end-to-end values returned after hits, refills, conflict evictions and write-around stores, the exact number of refill reads, the stall that appears only on the fifth back-to-back store, and the final memory contents after the queue drains in order.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int NLINES     = 64;
    localparam int LINE_BYTES = 16;

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(NLINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WSEL_W-1:0] wsel_t;

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_DRAIN = 2'd1,
        FSM_FILL  = 2'd2
    } fill_st_e;

    typedef struct packed {
        addr_t addr;
        word_t data;
    } wb_ent_t;

    function automatic tag_t get_tag(input addr_t a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic idx_t get_idx(input addr_t a);
        return a[OFF_W +: IDX_W];
    endfunction

    function automatic wsel_t get_wsel(input addr_t a);
        return a[BYTE_W +: WSEL_W];
    endfunction

    function automatic addr_t mk_addr(input tag_t t, input idx_t i, input wsel_t w);
        return {t, i, w, {BYTE_W{1'b0}}};
    endfunction
endpackage

// File: rtl/wtc_store.sv
module wtc_store
    import wtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  addr_t lk_addr,
    output logic  lk_hit,
    output word_t lk_data,
    input  logic  cpu_wr_acc,
    input  word_t cpu_wr_data,
    input  logic  fill_en,
    input  logic  fill_last,
    input  tag_t  fill_tag,
    input  idx_t  fill_idx,
    input  wsel_t fill_wsel,
    input  word_t fill_data
);
    tag_t              tag_q  [NLINES];
    word_t             data_q [NLINES][WORDS];
    logic [NLINES-1:0] valid_q;

    idx_t  lk_idx;
    wsel_t lk_wsel;

    assign lk_idx  = get_idx(lk_addr);
    assign lk_wsel = get_wsel(lk_addr);
    assign lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == get_tag(lk_addr));
    assign lk_data = data_q[lk_idx][lk_wsel];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (fill_en && fill_last) begin
            valid_q[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[fill_idx][fill_wsel] <= fill_data;
        end
        if (fill_en && fill_last) begin
            tag_q[fill_idx] <= fill_tag;
        end
        if (cpu_wr_acc && lk_hit) begin
            data_q[lk_idx][lk_wsel] <= cpu_wr_data;
        end
    end

    AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0)); // R4

    AST_WR_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_acc && !lk_hit) |=> $stable(valid_q)); // R8
endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf
    import wtc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  wb_ent_t push_ent,
    input  logic    pop,
    output wb_ent_t head,
    output logic    empty,
    output logic    full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    wb_ent_t            slot_q [DEPTH];
    logic [PTR_W-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]   cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign head  = slot_q[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[wr_ptr_q] <= push_ent;
    end

    AST_WB_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q != CNT_W'(DEPTH))); // R10

    AST_WB_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt_q != '0)); // R11
endmodule

// File: rtl/wtc_refill.sv
module wtc_refill
    import wtc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_miss,
    input  addr_t miss_addr,
    input  logic  wb_empty,
    input  logic  mem_ready,
    input  word_t mem_rdata,
    output logic  busy,
    output logic  filling,
    output addr_t rf_addr,
    output logic  fill_en,
    output logic  fill_last,
    output tag_t  fill_tag,
    output idx_t  fill_idx,
    output wsel_t fill_wsel,
    output word_t fill_data
);
    fill_st_e st_q;
    tag_t     tag_q;
    idx_t     idx_q;
    wsel_t    beat_q;

    assign busy      = (st_q != FSM_IDLE);
    assign filling   = (st_q == FSM_FILL);
    assign rf_addr   = mk_addr(tag_q, idx_q, beat_q);
    assign fill_en   = filling && mem_ready;
    assign fill_last = fill_en && (beat_q == WSEL_W'(WORDS - 1));
    assign fill_tag  = tag_q;
    assign fill_idx  = idx_q;
    assign fill_wsel = beat_q;
    assign fill_data = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FSM_IDLE;
            tag_q  <= '0;
            idx_q  <= '0;
            beat_q <= '0;
        end else begin
            case (st_q)
                FSM_IDLE: begin
                    if (rd_miss) begin
                        tag_q  <= get_tag(miss_addr);
                        idx_q  <= get_idx(miss_addr);
                        beat_q <= '0;
                        st_q   <= wb_empty ? FSM_FILL : FSM_DRAIN;
                    end
                end
                FSM_DRAIN: begin
                    if (wb_empty) st_q <= FSM_FILL;
                end
                FSM_FILL: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == WSEL_W'(WORDS - 1)) st_q <= FSM_IDLE;
                    end
                end
                default: st_q <= FSM_IDLE;
            endcase
        end
    end

    AST_FILL_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        filling |-> wb_empty); // R9

    AST_MISS_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_miss) |=> busy); // R5
endmodule

// File: rtl/wtc_cache_top.sv
module wtc_cache_top
    import wtc_pkg::*;
#(
    parameter int WB_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    logic    hit, busy, filling, wr_acc, rd_miss;
    logic    wb_empty, wb_full, wb_pop;
    wb_ent_t wb_head, wb_in;
    addr_t   rf_addr;
    logic    fill_en, fill_last;
    tag_t    fill_tag;
    idx_t    fill_idx;
    wsel_t   fill_wsel;
    word_t   fill_data;

    assign rd_miss   = cpu_req && !cpu_we && !hit;
    assign wr_acc    = cpu_req && cpu_we && !wb_full && !busy;
    assign cpu_stall = cpu_req && (cpu_we ? (wb_full || busy) : (!hit || busy));
    assign wb_in     = '{addr: {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}, data: cpu_wdata};
    assign wb_pop    = !filling && !wb_empty && mem_ready;

    always_comb begin
        if (filling) begin
            mem_req   = 1'b1;
            mem_we    = 1'b0;
            mem_addr  = rf_addr;
            mem_wdata = '0;
        end else begin
            mem_req   = !wb_empty;
            mem_we    = 1'b1;
            mem_addr  = wb_head.addr;
            mem_wdata = wb_head.data;
        end
    end

    wtc_store u_store (
        .clk        (clk),
        .rst        (rst),
        .lk_addr    (cpu_addr),
        .lk_hit     (hit),
        .lk_data    (cpu_rdata),
        .cpu_wr_acc (wr_acc),
        .cpu_wr_data(cpu_wdata),
        .fill_en    (fill_en),
        .fill_last  (fill_last),
        .fill_tag   (fill_tag),
        .fill_idx   (fill_idx),
        .fill_wsel  (fill_wsel),
        .fill_data  (fill_data)
    );

    wtc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
        .clk     (clk),
        .rst     (rst),
        .push    (wr_acc),
        .push_ent(wb_in),
        .pop     (wb_pop),
        .head    (wb_head),
        .empty   (wb_empty),
        .full    (wb_full)
    );

    wtc_refill u_refill (
        .clk      (clk),
        .rst      (rst),
        .rd_miss  (rd_miss),
        .miss_addr(cpu_addr),
        .wb_empty (wb_empty),
        .mem_ready(mem_ready),
        .mem_rdata(mem_rdata),
        .busy     (busy),
        .filling  (filling),
        .rf_addr  (rf_addr),
        .fill_en  (fill_en),
        .fill_last(fill_last),
        .fill_tag (fill_tag),
        .fill_idx (fill_idx),
        .fill_wsel(fill_wsel),
        .fill_data(fill_data)
    );

    AST_WR_QUEUED: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !wb_empty); // R10
endmodule

// File: tb/wtc_cache_top_tb.sv
module wtc_cache_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int n_run = 0;
    int n_fail = 0;
    int mem_lat = 2;
    int lat_cnt = 0;
    int rd_beats = 0;
    int cycles = 0;

    logic [31:0] mem     [4096];
    logic [31:0] ref_mem [4096];

    always #2.5 clk = ~clk;

    wtc_cache_top dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_ready = mem_req && (lat_cnt >= mem_lat);
    assign mem_rdata = mem[mem_addr[13:2]];

    always @(posedge clk) begin
        if (rst || !mem_req || mem_ready) lat_cnt <= 0;
        else lat_cnt <= lat_cnt + 1;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        if (mem_req && mem_ready && !mem_we) rd_beats <= rd_beats + 1;
    end

    function automatic logic [31:0] pat(input int i);
        return 32'h1000_0000 + 32'(i * 4);
    endfunction

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                         output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        stalls = 0;
        while (cpu_stall) begin
            @(negedge clk); #1;
            stalls++;
        end
        rd = cpu_rdata;
        if (we) ref_mem[a[13:2]] = d;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wait_drain();
        @(negedge clk);
        while (mem_req) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wd;
        logic        miss;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_0100, 32'h0,          1'b1},
        '{1'b0, 32'h0000_0104, 32'h0,          1'b0},
        '{1'b0, 32'h0000_010C, 32'h0,          1'b0},
        '{1'b1, 32'h0000_0108, 32'hDEAD_0001,  1'b0},
        '{1'b0, 32'h0000_0108, 32'h0,          1'b0},
        '{1'b1, 32'h0000_2000, 32'hCAFE_0002,  1'b0},
        '{1'b0, 32'h0000_2000, 32'h0,          1'b1},
        '{1'b0, 32'h0000_0100, 32'h0,          1'b0},
        '{1'b0, 32'h0000_0500, 32'h0,          1'b1},
        '{1'b0, 32'h0000_0100, 32'h0,          1'b1},
        '{1'b0, 32'h0000_3FFC, 32'h0,          1'b1},
        '{1'b0, 32'h0000_3FF0, 32'h0,          1'b0},
        '{1'b0, 32'h0000_3FFE, 32'h0,          1'b0}
    };

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                n_run++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        int          st;
        int          beats0;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = pat(i);
            ref_mem[i] = pat(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(cpu_stall == 1'b0, "R4 stall low after reset", {31'b0, cpu_stall}, 32'h0);
        chk(mem_req == 1'b0, "R4 no memory request after reset", {31'b0, mem_req}, 32'h0);

        // Table walk: R3/R5/R6/R7/R8/R2/R1 via hit-or-miss and returned data
        for (int i = 0; i < NV; i++) begin
            beats0 = rd_beats;
            do_op(VECS[i].we, VECS[i].addr, VECS[i].wd, rd, st);
            chk((st > 0) == VECS[i].miss, $sformatf("R3/R5 vector %0d stall", i),
                32'(st), {31'b0, VECS[i].miss});
            if (!VECS[i].we) begin
                chk(rd == ref_mem[VECS[i].addr[13:2]], $sformatf("R1/R7/R8 vector %0d data", i),
                    rd, ref_mem[VECS[i].addr[13:2]]);
                @(negedge clk);
                chk((rd_beats - beats0) == (VECS[i].miss ? 4 : 0),
                    $sformatf("R5/R6 vector %0d read beats", i),
                    32'(rd_beats - beats0), VECS[i].miss ? 32'd4 : 32'd0);
            end
        end

        wait_drain();
        chk(mem[32'h108 >> 2] == 32'hDEAD_0001, "R7 store hit reached memory",
            mem[32'h108 >> 2], 32'hDEAD_0001);
        chk(mem[32'h2000 >> 2] == 32'hCAFE_0002, "R8 store miss reached memory",
            mem[32'h2000 >> 2], 32'hCAFE_0002);

        // R10: slow memory, five back-to-back store misses
        mem_lat = 6;
        do_op(1'b1, 32'h3000, 32'hA000_0001, rd, st);
        chk(st == 0, "R10 store 1 no stall", 32'(st), 32'h0);
        do_op(1'b1, 32'h3004, 32'hA000_0002, rd, st);
        chk(st == 0, "R10 store 2 no stall", 32'(st), 32'h0);
        do_op(1'b1, 32'h3008, 32'hA000_0003, rd, st);
        chk(st == 0, "R10 store 3 no stall", 32'(st), 32'h0);
        do_op(1'b1, 32'h300C, 32'hA000_0004, rd, st);
        chk(st == 0, "R10 store 4 no stall", 32'(st), 32'h0);
        do_op(1'b1, 32'h3000, 32'hA000_0005, rd, st);
        chk(st > 0, "R10 store 5 stalls on full queue", 32'(st), 32'h1);

        // R9: load miss right away must see queued stores
        do_op(1'b0, 32'h3008, 32'h0, rd, st);
        chk(rd == 32'hA000_0003, "R9 refill after drain", rd, 32'hA000_0003);
        do_op(1'b0, 32'h3000, 32'h0, rd, st);
        chk(rd == 32'hA000_0005, "R11 later store wins in refilled line", rd, 32'hA000_0005);
        chk(st == 0, "R6 same line hit after refill", 32'(st), 32'h0);

        wait_drain();
        chk(mem[32'h3000 >> 2] == 32'hA000_0005, "R11 memory holds last store",
            mem[32'h3000 >> 2], 32'hA000_0005);
        chk(mem[32'h300C >> 2] == 32'hA000_0004, "R11 queued store drained",
            mem[32'h300C >> 2], 32'hA000_0004);

        // R2: index 16 now holds tag of 0x100; 0x500 conflicts again
        mem_lat = 1;
        do_op(1'b0, 32'h0500, 32'h0, rd, st);
        chk(st > 0, "R2 conflicting tag misses", 32'(st), 32'h1);
        chk(rd == ref_mem[32'h500 >> 2], "R2 conflict data", rd, ref_mem[32'h500 >> 2]);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule